// File: doc/BRIEF.md
# Three-Sweep Interference Rejection Filter

This block cleans one-bit radar video before it is written to display memory. Each transmission (sweep) delivers a fixed number of range cells. The block keeps the three most recent completed sweeps in a small rotating bit store. For every incoming cell it produces one output bit, built from the stored bits at the same range position.

With rejection enabled, a return must show up in the middle stored sweep and in at least one of its two neighbours. A pulse that is not locked to the transmit timing lands in one sweep only, so it is dropped. With rejection disabled, the three stored bits are ORed. The filtered bit is then ORed with a range-marker bit. While the standby flag is high, the written bit is forced to zero.

Because only completed sweeps are read, the output follows the input by two transmissions. The output is centred on the sweep two back from the one being received. The incoming sample overwrites the oldest sweep's bit at the same cell, after that bit has been read.

Top module: `ir_sweep_filter`

## Requirements
- R1: While reset is asserted, videoValid and videoOut are both 0, and every stored sweep bit is cleared.
- R2: A sweepStart pulse restarts the cell count at cell 0 and rotates the store so that the oldest sweep slot receives the new sweep. Samples that arrive before the first sweepStart after reset are ignored and give no videoValid. A sample that arrives in the same cycle as sweepStart is also ignored.
- R3: A sweep accepts at most CELLS samples (default 112). Any further samples before the next sweepStart are ignored: they produce no videoValid and are not stored.
- R4: Each accepted sample produces videoValid high for exactly one cycle, on the clock edge after the sample. videoOut changes only on that edge and holds its value in between.
- R5: The output for cell k of sweep n uses the bits stored at cell k for sweeps n-3 (older), n-2 (middle) and n-1 (newer). The current sample is stored, and it reaches the output only in later sweeps.
- R6: With irEnable=1, the filtered bit is middle AND (older OR newer). A bit present in a single sweep is removed.
- R7: With irEnable=0, the filtered bit is older OR middle OR newer.
- R8: Sweeps not yet captured since reset contribute 0.
- R9: videoOut is the filtered bit ORed with the markerIn bit given with the sample.
- R10: When standby is 1 with a sample, videoOut is 0 and videoValid still fires. The sample is still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| sweepStart | input | 1 | One-cycle strobe marking the start of a transmission |
| sampleValid | input | 1 | A range cell sample is present on videoIn |
| videoIn | input | 1 | Quantised video bit for the current cell |
| irEnable | input | 1 | 1 selects interference rejection, 0 selects three-sweep OR |
| standby | input | 1 | Forces the written video bit to 0 |
| markerIn | input | 1 | Range-marker bit merged into the output |
| videoOut | output | 1 | Processed video bit for display memory |
| videoValid | output | 1 | One-cycle strobe marking a new videoOut |

## Verification
The assertions rely on sweepStart being a single-cycle strobe. They also rely on irEnable, standby and markerIn being valid in the same cycle as sampleValid, and on sampleValid never being X once reset is released. The bench keeps within these limits. It drives all inputs on the falling edge and raises sweepStart for one cycle on its own, with no sample beside it. It presents the mode flags alongside every sample, one sample per two cycles. It then compares each output against a three-sweep history model of its own.

// File: rtl/irf_pkg.sv
package irf_pkg;
  // Three stored sweeps is the filter's defining property, not a tuning knob.
  localparam int SLOTS  = 3;
  localparam int SLOT_W = $clog2(SLOTS);

  // Strobes from control to the datapath for one range cell.
  typedef struct packed {
    logic              accept;
    logic [SLOT_W-1:0] oldSlot;
    logic [SLOT_W-1:0] midSlot;
    logic [SLOT_W-1:0] newSlot;
  } irf_strobe_t;
endpackage

// File: rtl/irf_ctrl.sv
module irf_ctrl
  import irf_pkg::*;
#(
  parameter int CELLS = 112,
  parameter int IDXW  = $clog2(CELLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sweepStart,
  input  logic            sampleValid,
  output irf_strobe_t     strobe,
  output logic [IDXW-1:0] cellIdx
);
  localparam logic [IDXW-1:0] IDLE_IDX = IDXW'(CELLS);

  logic [IDXW-1:0]   cellReg;
  logic [SLOT_W-1:0] wrSlot;

  function automatic logic [SLOT_W-1:0] prevSlot(input logic [SLOT_W-1:0] s);
    return (s == '0) ? SLOT_W'(SLOTS - 1) : s - SLOT_W'(1);
  endfunction

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + SLOT_W'(1);
  endfunction

  // The cell counter parks at CELLS when idle, so nothing is accepted
  // before the first sweep or after a sweep is full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cellReg <= IDLE_IDX;
      wrSlot  <= SLOT_W'(SLOTS - 1);
    end else if (sweepStart) begin
      cellReg <= '0;
      wrSlot  <= nextSlot(wrSlot);
    end else if (strobe.accept) begin
      cellReg <= cellReg + IDXW'(1);
    end
  end

  always_comb begin
    strobe.accept  = sampleValid && !sweepStart && (cellReg < IDLE_IDX);
    strobe.oldSlot = wrSlot;                 // read first, then overwritten
    strobe.newSlot = prevSlot(wrSlot);
    strobe.midSlot = prevSlot(prevSlot(wrSlot));
  end

  assign cellIdx = cellReg;

  assert_cell_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cellReg <= IDLE_IDX);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sweepStart |=> (cellReg == '0));

  assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrSlot < SLOT_W'(SLOTS));

  assert_slots_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.oldSlot != strobe.midSlot) && (strobe.midSlot != strobe.newSlot)
    && (strobe.oldSlot != strobe.newSlot));

  assert_full_sweep_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cellReg == IDLE_IDX && !sweepStart) |=> (cellReg == IDLE_IDX));
endmodule

// File: rtl/irf_combine.sv
module irf_combine (
  input  logic oldBit,
  input  logic midBit,
  input  logic newBit,
  input  logic irEnable,
  output logic outBit
);
  logic pairHit;
  logic anyHit;

  // Middle sweep paired with either neighbour survives rejection.
  assign pairHit = midBit & (oldBit | newBit);
  assign anyHit  = oldBit | midBit | newBit;
  assign outBit  = irEnable ? pairHit : anyHit;
endmodule

// File: rtl/irf_datapath.sv
module irf_datapath
  import irf_pkg::*;
#(
  parameter int CELLS = 112,
  parameter int IDXW  = $clog2(CELLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  irf_strobe_t     strobe,
  input  logic [IDXW-1:0] cellIdx,
  input  logic            videoIn,
  input  logic            irEnable,
  input  logic            standby,
  input  logic            markerIn,
  output logic            videoOut,
  output logic            videoValid
);
  localparam int CIW = (CELLS > 1) ? $clog2(CELLS) : 1;

  logic [CIW-1:0]   cIdx;
  logic [SLOTS-1:0] cellBits;
  logic             oldBit, midBit, newBit;
  logic             filtBit;
  logic             writeBit;

  assign cIdx = cellIdx[CIW-1:0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CELLS-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        row <= '0;
      else if (strobe.accept && strobe.oldSlot == SLOT_W'(s))
        row[cIdx] <= videoIn;
    end

    assign cellBits[s] = row[cIdx];
  end

  assign oldBit = cellBits[strobe.oldSlot];
  assign midBit = cellBits[strobe.midSlot];
  assign newBit = cellBits[strobe.newSlot];

  irf_combine u_combine (
    .oldBit  (oldBit),
    .midBit  (midBit),
    .newBit  (newBit),
    .irEnable(irEnable),
    .outBit  (filtBit)
  );

  assign writeBit = !standby && (filtBit || markerIn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      videoValid <= 1'b0;
      videoOut   <= 1'b0;
    end else begin
      videoValid <= strobe.accept;
      if (strobe.accept) videoOut <= writeBit;
    end
  end

  assert_valid_follows_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    videoValid == $past(strobe.accept));

  assert_out_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.accept) |-> $stable(videoOut));

  assert_lone_pulse_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.accept && irEnable && !midBit && !markerIn) |-> !videoOut);

  assert_bypass_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.accept && !irEnable && !standby && (oldBit || midBit || newBit))
      |-> videoOut);

  assert_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.accept && markerIn && !standby) |-> videoOut);

  assert_standby_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.accept && standby) |-> (videoValid && !videoOut));
endmodule

// File: rtl/ir_sweep_filter.sv
module ir_sweep_filter
  import irf_pkg::*;
#(
  parameter int CELLS = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sweepStart,
  input  logic sampleValid,
  input  logic videoIn,
  input  logic irEnable,
  input  logic standby,
  input  logic markerIn,
  output logic videoOut,
  output logic videoValid
);
  localparam int IDXW = $clog2(CELLS + 1);

  irf_strobe_t     strobe;
  logic [IDXW-1:0] cellIdx;

  irf_ctrl #(.CELLS(CELLS), .IDXW(IDXW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sweepStart (sweepStart),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .cellIdx    (cellIdx)
  );

  irf_datapath #(.CELLS(CELLS), .IDXW(IDXW)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .cellIdx   (cellIdx),
    .videoIn   (videoIn),
    .irEnable  (irEnable),
    .standby   (standby),
    .markerIn  (markerIn),
    .videoOut  (videoOut),
    .videoValid(videoValid)
  );
endmodule

// File: tb/ir_sweep_filter_test.sv
`timescale 1ns/1ps
module ir_sweep_filter_test;
  localparam int CELLS = 112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sweepStart = 1'b0;
  logic sampleValid = 1'b0;
  logic videoIn = 1'b0;
  logic irEnable = 1'b0;
  logic standby = 1'b0;
  logic markerIn = 1'b0;
  logic videoOut;
  logic videoValid;

  int checks = 0;
  int fails = 0;
  int sweepNo = 0;
  logic [CELLS-1:0] hNew = '0;
  logic [CELLS-1:0] hMid = '0;
  logic [CELLS-1:0] hOld = '0;

  always #2 clk = ~clk;

  ir_sweep_filter #(.CELLS(CELLS)) uut (
    .clk(clk), .rst_n(rst_n), .sweepStart(sweepStart), .sampleValid(sampleValid),
    .videoIn(videoIn), .irEnable(irEnable), .standby(standby), .markerIn(markerIn),
    .videoOut(videoOut), .videoValid(videoValid)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic pat(input int s, input int c);
    return (c >= 20 && c <= 30) || (((s * 7 + c * 13) % 23) == 0) ||
           (c >= 60 && c <= 63 && (s % 2) == 0);
  endfunction

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(videoValid, 1'b0, "R1", "valid in reset");
    chk(videoOut, 1'b0, "R1", "out in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(videoValid, 1'b0, "R1", "valid after release");
  endtask

  task automatic testIgnoreBeforeStart();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      videoIn = 1'b1; markerIn = 1'b1; sampleValid = 1'b1;
      @(negedge clk);
      sampleValid = 1'b0; markerIn = 1'b0;
      chk(videoValid, 1'b0, "R2", "sample before first sweep");
    end
  endtask

  task automatic runSweep(input logic ir, input logic mk, input logic sb,
                          input int extra, input string req);
    logic [CELLS-1:0] cur = '0;
    @(negedge clk); sweepStart = 1'b1;
    @(negedge clk); sweepStart = 1'b0;
    for (int k = 0; k < CELLS + extra; k++) begin
      logic v, m, filt, expOut;
      @(negedge clk);
      if (k > 0) chk(videoValid, 1'b0, "R4", "valid width");
      v = pat(sweepNo, k);
      m = mk && ((k % 28) == 5);
      videoIn = v; markerIn = m; irEnable = ir; standby = sb; sampleValid = 1'b1;
      @(negedge clk);
      sampleValid = 1'b0;
      if (k < CELLS) begin
        cur[k] = v;
        filt = ir ? (hMid[k] & (hOld[k] | hNew[k])) : (hOld[k] | hMid[k] | hNew[k]);
        expOut = !sb && (filt || m);
        chk(videoValid, 1'b1, "R4", $sformatf("valid sweep %0d cell %0d", sweepNo, k));
        chk(videoOut, expOut, req, $sformatf("sweep %0d cell %0d", sweepNo, k));
      end else begin
        chk(videoValid, 1'b0, "R3", $sformatf("overrun sample %0d", k));
      end
    end
    hOld = hMid; hMid = hNew; hNew = cur;
    sweepNo++;
    markerIn = 1'b0; standby = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testIgnoreBeforeStart();
    runSweep(1'b0, 1'b0, 1'b0, 0, "R8 R7 R2");
    runSweep(1'b0, 1'b0, 1'b0, 0, "R8 R7");
    runSweep(1'b1, 1'b0, 1'b0, 0, "R8 R6");
    runSweep(1'b1, 1'b0, 1'b0, 0, "R5 R6");
    runSweep(1'b1, 1'b0, 1'b0, 0, "R5 R6");
    runSweep(1'b0, 1'b0, 1'b0, 0, "R5 R7");
    runSweep(1'b1, 1'b1, 1'b0, 0, "R9");
    runSweep(1'b0, 1'b1, 1'b0, 0, "R9 R7");
    runSweep(1'b1, 1'b0, 1'b1, 0, "R10");
    runSweep(1'b1, 1'b0, 1'b0, 4, "R3 R10");
    runSweep(1'b1, 1'b0, 1'b0, 0, "R3 R5");
    runSweep(1'b0, 1'b0, 1'b0, 0, "R3 R7");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule